// File: doc/BRIEF.md
# Sleep and Idle Wakeup Controller

This controller manages the power state of a small processor core. Software asks for a low-power state by pulsing a request with a mode code. The controller then stops the core clock, and in the deepest state it also stops the auxiliary oscillator/timer clock. It leaves the low-power state only when an input that is allowed to wake that state fires.

There are three low-power states, and each one has its own set of wake sources. Sleep stops every clock and responds only to an I/O event. Idle keeps the auxiliary oscillator and the timer running, so a timer overflow can also wake it. Idle-with-audio additionally accepts an audio detection event.

On every wake the controller records which source caused it, so software can read the reason afterwards. A separate control register write sets or clears a bit that gates the multiplier unit clock, independently of the power state.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After a synchronous reset, cur_mode is 0 (Active), core_clk_en, aux_clk_en and mul_clk_en are 1, and wake_cause is 0.
- R2: In Active, a mode_req pulse with mode_code 0 (Sleep), 1 (Idle) or 2 (Idle-with-audio) moves cur_mode to 1, 2 or 3 respectively on the next clock edge, provided no wake source allowed in the target state is asserted.
- R3: core_clk_en is 1 only in Active. aux_clk_en is 0 only in Sleep. Both outputs change on the same edge as cur_mode.
- R4: In Sleep only io_evt wakes the core. tmr_ovf and audio_evt leave cur_mode and wake_cause unchanged.
- R5: In Idle, io_evt or tmr_ovf wakes the core. audio_evt is ignored.
- R6: In Idle-with-audio, io_evt, tmr_ovf or audio_evt wakes the core.
- R7: A wake sets cur_mode to 0 and core_clk_en to 1 on the next edge. On that same edge wake_cause is loaded with 1 (I/O), 2 (timer) or 3 (audio). When several sources fire together, I/O has priority over timer, and timer has priority over audio.
- R8: mode_req is ignored when cur_mode is not Active, and it is ignored when mode_code is 3.
- R9: If a source that is allowed in the requested state is already asserted with the request, the controller stays Active and wake_cause is loaded as in R7.
- R10: A write with ctl_wr loads bit 4 of ctl_wdata into the multiplier enable bit (reset value 1). mul_clk_en equals that bit while Active and is 0 in any low-power state.
- R11: wake_cause keeps its value until the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 1 | Low-power request pulse |
| mode_code | input | 2 | Requested state: 0 Sleep, 1 Idle, 2 Idle-with-audio |
| io_evt | input | 1 | I/O wake event |
| tmr_ovf | input | 1 | Timer overflow interrupt request |
| audio_evt | input | 1 | Audio detection event |
| ctl_wr | input | 1 | Clock-control register write strobe |
| ctl_wdata | input | 8 | Clock-control write data; bit 4 is the multiplier enable |
| core_clk_en | output | 1 | Core clock enable |
| aux_clk_en | output | 1 | Auxiliary oscillator and timer clock enable |
| mul_clk_en | output | 1 | Multiplier unit clock enable |
| cur_mode | output | 2 | Current state: 0 Active, 1 Sleep, 2 Idle, 3 Idle-with-audio |
| wake_cause | output | 2 | Last wake reason: 0 none, 1 I/O, 2 timer, 3 audio |

## Verification
A mode request and a wake event can arrive in the same cycle. In that case the state entry has to be cancelled, and the cause is still recorded. The bench provokes this case with directed steps that raise the request together with a source that the target state allows, and with a source that it does not allow. It also produces the case at random, by driving requests and sparse wake events independently. A cycle model in the bench decides whether the state should stay Active or move, what cause should be latched, and which enables should result. Each registered output is compared one step after its edge.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_IDLE   = 2'd2,
    PM_IDLE_A = 2'd3
  } pm_state_t;

  typedef enum logic [1:0] {
    WC_NONE  = 2'd0,
    WC_IO    = 2'd1,
    WC_TIMER = 2'd2,
    WC_AUDIO = 2'd3
  } wake_code_t;
endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter
  import pwr_pkg::*;
(
  input  pm_state_t  eval_state,
  input  logic       io_evt,
  input  logic       tmr_ovf,
  input  logic       audio_evt,
  output logic       hit,
  output wake_code_t code
);
  logic io_ok, tmr_ok, aud_ok;

  // Sources allowed for the state being evaluated
  always_comb begin
    io_ok  = (eval_state != PM_ACTIVE) && io_evt;
    tmr_ok = ((eval_state == PM_IDLE) || (eval_state == PM_IDLE_A)) && tmr_ovf;
    aud_ok = (eval_state == PM_IDLE_A) && audio_evt;
  end

  // Fixed priority: I/O, then timer, then audio
  always_comb begin
    hit  = io_ok || tmr_ok || aud_ok;
    if (io_ok)       code = WC_IO;
    else if (tmr_ok) code = WC_TIMER;
    else if (aud_ok) code = WC_AUDIO;
    else             code = WC_NONE;
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_req,
  input  logic [1:0] mode_code,
  input  logic       io_evt,
  input  logic       tmr_ovf,
  input  logic       audio_evt,
  input  logic       wake_hit,
  input  wake_code_t wake_code,
  output pm_state_t  eval_state,
  output pm_state_t  state,
  output pm_state_t  nxt_state,
  output wake_code_t cause
);
  pm_state_t  target;
  logic       req_ok;
  wake_code_t nxt_cause;

  always_comb begin
    case (mode_code)
      2'd0:    target = PM_SLEEP;
      2'd1:    target = PM_IDLE;
      2'd2:    target = PM_IDLE_A;
      default: target = PM_ACTIVE;
    endcase
    req_ok     = (state == PM_ACTIVE) && mode_req && (mode_code != 2'd3);
    eval_state = req_ok ? target : state;
  end

  always_comb begin
    nxt_state = state;
    nxt_cause = cause;
    if (wake_hit) begin
      nxt_state = PM_ACTIVE;
      nxt_cause = wake_code;
    end else if (req_ok) begin
      nxt_state = target;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PM_ACTIVE;
      cause <= WC_NONE;
    end else begin
      state <= nxt_state;
      cause <= nxt_cause;
    end
  end

  p_sleep_io_only_r4: assert property (@(posedge clk) disable iff (rst)
    (state == PM_SLEEP && !io_evt) |=> (state == PM_SLEEP));
  p_idle_no_audio_r5: assert property (@(posedge clk) disable iff (rst)
    (state == PM_IDLE && !io_evt && !tmr_ovf) |=> (state == PM_IDLE));
  p_idle_a_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (state == PM_IDLE_A && (io_evt || tmr_ovf || audio_evt)) |=> (state == PM_ACTIVE));
  p_io_cause_r7: assert property (@(posedge clk) disable iff (rst)
    (state != PM_ACTIVE && io_evt) |=> (cause == WC_IO));
  p_req_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (state != PM_ACTIVE) |=> (state == PM_ACTIVE || $stable(state)));
  p_cause_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (state == PM_ACTIVE && !mode_req) |=> $stable(cause));
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_pkg::*;
#(
  parameter int CTL_W   = 8,
  parameter int MUL_BIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  pm_state_t        nxt_state,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             core_clk_en,
  output logic             aux_clk_en,
  output logic             mul_clk_en
);
  logic mul_bit, nxt_mul_bit;

  always_comb nxt_mul_bit = ctl_wr ? ctl_wdata[MUL_BIT] : mul_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mul_bit     <= 1'b1;
      core_clk_en <= 1'b1;
      aux_clk_en  <= 1'b1;
      mul_clk_en  <= 1'b1;
    end else begin
      mul_bit     <= nxt_mul_bit;
      core_clk_en <= (nxt_state == PM_ACTIVE);
      aux_clk_en  <= (nxt_state != PM_SLEEP);
      mul_clk_en  <= nxt_mul_bit && (nxt_state == PM_ACTIVE);
    end
  end

  p_mul_off_r10: assert property (@(posedge clk) disable iff (rst)
    !core_clk_en |-> !mul_clk_en);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_pkg::*;
#(
  parameter int CTL_W   = 8,
  parameter int MUL_BIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_req,
  input  logic [1:0]       mode_code,
  input  logic             io_evt,
  input  logic             tmr_ovf,
  input  logic             audio_evt,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             core_clk_en,
  output logic             aux_clk_en,
  output logic             mul_clk_en,
  output logic [1:0]       cur_mode,
  output logic [1:0]       wake_cause
);
  pm_state_t  eval_state, state, nxt_state;
  wake_code_t wcode, cause;
  logic       whit;

  pwr_wake_filter u_filter (
    .eval_state(eval_state), .io_evt(io_evt), .tmr_ovf(tmr_ovf),
    .audio_evt(audio_evt), .hit(whit), .code(wcode)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .mode_req(mode_req), .mode_code(mode_code),
    .io_evt(io_evt), .tmr_ovf(tmr_ovf), .audio_evt(audio_evt),
    .wake_hit(whit), .wake_code(wcode), .eval_state(eval_state),
    .state(state), .nxt_state(nxt_state), .cause(cause)
  );

  pwr_clk_gate #(.CTL_W(CTL_W), .MUL_BIT(MUL_BIT)) u_gate (
    .clk(clk), .rst(rst), .nxt_state(nxt_state), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .core_clk_en(core_clk_en),
    .aux_clk_en(aux_clk_en), .mul_clk_en(mul_clk_en)
  );

  assign cur_mode   = state;
  assign wake_cause = cause;

  p_core_en_r3: assert property (@(posedge clk) disable iff (rst)
    core_clk_en == (cur_mode == 2'd0));
  p_aux_en_r3: assert property (@(posedge clk) disable iff (rst)
    aux_clk_en == (cur_mode != 2'd1));
endmodule

// File: tb/tb_pwr_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_wake_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic mode_req = 0, io_evt = 0, tmr_ovf = 0, audio_evt = 0, ctl_wr = 0;
  logic [1:0] mode_code = 0;
  logic [7:0] ctl_wdata = 0;
  logic core_clk_en, aux_clk_en, mul_clk_en;
  logic [1:0] cur_mode, wake_cause;
  int n_run = 0, n_fail = 0;
  logic [1:0] e_mode = 0, e_cause = 0;
  logic e_mul = 1;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_wake_ctrl dut (
    .clk(clk), .rst(rst), .mode_req(mode_req), .mode_code(mode_code),
    .io_evt(io_evt), .tmr_ovf(tmr_ovf), .audio_evt(audio_evt),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .core_clk_en(core_clk_en),
    .aux_clk_en(aux_clk_en), .mul_clk_en(mul_clk_en),
    .cur_mode(cur_mode), .wake_cause(wake_cause)
  );

  function automatic logic [1:0] wake_of(logic [1:0] m, logic i, logic t, logic a);
    if (m != 0 && i) return 2'd1;
    if ((m == 2 || m == 3) && t) return 2'd2;
    if (m == 3 && a) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "cur_mode", cur_mode, e_mode);
    chk(tag, "wake_cause", wake_cause, e_cause);
    chk("R3", "core_clk_en", core_clk_en, e_mode == 0);
    chk("R3", "aux_clk_en", aux_clk_en, e_mode != 1);
    chk("R10", "mul_clk_en", mul_clk_en, e_mul && e_mode == 0);
  endtask

  task automatic step(string tag, logic rq, logic [1:0] cd, logic i, logic t,
                      logic a, logic w, logic [7:0] wd);
    logic [1:0] c;
    @(negedge clk);
    mode_req = rq; mode_code = cd; io_evt = i; tmr_ovf = t; audio_evt = a;
    ctl_wr = w; ctl_wdata = wd;
    if (e_mode == 0) begin
      if (rq && cd != 3) begin
        c = wake_of(cd + 2'd1, i, t, a);
        if (c != 0) e_cause = c;
        else e_mode = cd + 2'd1;
      end
    end else begin
      c = wake_of(e_mode, i, t, a);
      if (c != 0) begin e_mode = 0; e_cause = c; end
    end
    if (w) e_mul = wd[4];
    @(posedge clk); #1;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    check_all("R1");
    // R2 + R4: sleep ignores timer/audio, wakes on io
    step("R2", 1, 2'd0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 1, 0, 0);
    step("R8", 1, 2'd1, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 1, 1, 1, 0, 0);
    // R5: idle ignores audio, wakes on timer
    step("R2", 1, 2'd1, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 0, 0);
    step("R5", 0, 0, 0, 1, 1, 0, 0);
    // R6: idle-audio wakes on audio
    step("R2", 1, 2'd2, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 0);
    // R7 priority: io over timer and audio
    step("R2", 1, 2'd2, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 1, 1, 0, 0);
    // R8: code 3 ignored
    step("R8", 1, 2'd3, 0, 0, 0, 0, 0);
    // R9: pending allowed source cancels entry; disallowed one does not
    step("R9", 1, 2'd1, 0, 1, 0, 0, 0);
    step("R9", 1, 2'd0, 0, 1, 1, 0, 0);
    step("R4", 0, 0, 1, 0, 0, 0, 0);
    // R10: multiplier enable
    step("R10", 0, 0, 0, 0, 0, 1, 8'h00);
    step("R10", 1, 2'd1, 0, 0, 0, 1, 8'h10);
    step("R10", 0, 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < 4000; k++) begin
      step("R2", ($urandom % 4) == 0, 2'($urandom), ($urandom % 10) == 0,
           ($urandom % 8) == 0, ($urandom % 6) == 0, ($urandom % 16) == 0,
           8'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule